// File: doc/BRIEF.md
# Partitioned SIMD Saturating Adder

This block is a purely combinational 64-bit adder/subtractor whose carry path can be cut at byte boundaries. A two-bit lane select makes the same datapath act as eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit word. Every lane adds or subtracts on its own, and no carry or borrow crosses a lane edge.

Each lane reports overflow. Signed mode uses the two's-complement sign rules. Unsigned mode uses carry-out for addition and borrow for subtraction. With clamping off, a lane returns its modulo result. With clamping on, an overflowing lane returns the extreme value on the side it overflowed toward. The overflow output has one bit per byte. A wide lane repeats its single flag across all of its bytes, so a consumer can mask results byte by byte without decoding the lane size.

Top module: `simd_sat_adder`

## Requirements
- R1: `lane_sel` selects the lane width: 2'b00 gives 8-bit lanes, 2'b01 gives 16-bit lanes, 2'b10 gives 32-bit lanes and 2'b11 gives one 64-bit lane. Lane k covers bits [k*W+W-1 : k*W]. No carry or borrow passes from one lane into the next.
- R2: With `sub_en`=0, each lane of `result` equals (a + b) mod 2^W when no clamping applies.
- R3: With `sub_en`=1, each lane is computed as a + (~b) + 1 and equals (a - b) mod 2^W when no clamping applies.
- R4: With `signed_en`=1 and addition, a lane overflows only when both operands have the same sign and the result sign differs from it. Operands of opposite sign never overflow.
- R5: With `signed_en`=1 and subtraction, a lane overflows only when the operand signs differ and the result sign differs from the sign of a.
- R6: With `signed_en`=0, a lane overflows on carry-out of its top bit for addition, and on borrow (b > a) for subtraction.
- R7: `lane_ovf` bit i reports the overflow of the lane that contains byte i (bits [8i+7:8i]). All bytes of one lane carry the same flag.
- R8: With `sat_en`=0, every lane returns its wrapped result, even when its overflow flag is set.
- R9: With `sat_en`=1 and `signed_en`=1, an overflowing lane returns 0x7F..FF when it overflows upward (a was non-negative) and 0x80..00 when it overflows downward.
- R10: With `sat_en`=1 and `signed_en`=0, an overflowing add lane returns all ones and an overflowing subtract lane returns zero.
- R11: With `sat_en`=1, a lane that does not overflow returns its wrapped result unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 64 | First operand, packed lanes |
| op_b | input | 64 | Second operand, packed lanes |
| lane_sel | input | 2 | Lane width select (00=8, 01=16, 10=32, 11=64 bits) |
| sub_en | input | 1 | 1 = subtract op_b from op_a, 0 = add |
| signed_en | input | 1 | 1 = signed overflow rules, 0 = unsigned |
| sat_en | input | 1 | 1 = clamp overflowing lanes, 0 = wrap |
| result | output | 64 | Packed per-lane result |
| lane_ovf | output | 8 | Per-byte copy of the owning lane's overflow flag |

## Verification
The bench builds the block with its default parameters: a 64-bit word and 8-bit slices. These give eight slices, so all four lane widths are reachable, and byte-0 carries can be seen stopping at the 8-, 16- and 32-bit boundaries. Random operands drawn from the extreme byte values 0x00, 0x7F, 0x80 and 0xFF push lanes onto the overflow edges in every combination of sign mode, direction and clamping. Directed cases pin down both signed clamp values, both unsigned clamp values and the opposite-sign add that must never flag.

// File: rtl/simd_pkg.sv
package simd_pkg;

    typedef enum logic [1:0] {
        LANE_8  = 2'b00,
        LANE_16 = 2'b01,
        LANE_32 = 2'b10,
        LANE_64 = 2'b11
    } lane_sel_e;

endpackage

// File: rtl/simd_lane_map.sv
module simd_lane_map
    import simd_pkg::*;
#(
    parameter int NB = 8
) (
    input  logic [1:0]    lane_sel,
    output logic [NB-1:0] first_byte,
    output logic [NB-1:0] last_byte
);

    typedef struct packed {
        logic [NB-1:0] first;
        logic [NB-1:0] last;
    } map_t;

    map_t map_d;
    int   lb;

    always_comb begin
        case (lane_sel_e'(lane_sel))
            LANE_8:  lb = 1;
            LANE_16: lb = 2;
            LANE_32: lb = 4;
            default: lb = NB;
        endcase
        if (lb > NB) lb = NB;
        for (int i = 0; i < NB; i++) begin
            map_d.first[i] = ((i & (lb - 1)) == 0);
            map_d.last[i]  = (((i + 1) & (lb - 1)) == 0);
        end
    end

    assign first_byte = map_d.first;
    assign last_byte  = map_d.last;

    // R1
    always_comb begin
        lane_bounds_chk: assert (first_byte[0] && last_byte[NB-1] &&
                                 ($countones(first_byte) == $countones(last_byte)))
            else $error("lane boundary map inconsistent");
    end

endmodule

// File: rtl/simd_slice_chain.sv
module simd_slice_chain #(
    parameter int NB = 8,
    parameter int BW = 8,
    localparam int WW = NB * BW
) (
    input  logic [WW-1:0] a,
    input  logic [WW-1:0] b,
    input  logic          sub_en,
    input  logic [NB-1:0] first_byte,
    output logic [WW-1:0] sum,
    output logic [WW-1:0] b_eff,
    output logic [NB-1:0] cout
);

    typedef struct packed {
        logic [WW-1:0] sum;
        logic [WW-1:0] beff;
        logic [NB-1:0] cout;
    } chain_t;

    chain_t       chain_d;
    logic         carry;
    logic         cin;
    logic [BW:0]  part;

    always_comb begin
        chain_d.beff = sub_en ? ~b : b;
        chain_d.sum  = '0;
        chain_d.cout = '0;
        carry        = 1'b0;
        cin          = 1'b0;
        part         = '0;
        for (int i = 0; i < NB; i++) begin
            // carry is cut at every lane start; subtraction injects +1 there
            cin  = first_byte[i] ? sub_en : carry;
            part = {1'b0, a[i*BW +: BW]} + {1'b0, chain_d.beff[i*BW +: BW]}
                 + {{BW{1'b0}}, cin};
            chain_d.sum[i*BW +: BW] = part[BW-1:0];
            chain_d.cout[i]         = part[BW];
            carry                   = part[BW];
        end
    end

    assign sum   = chain_d.sum;
    assign b_eff = chain_d.beff;
    assign cout  = chain_d.cout;

endmodule

// File: rtl/simd_lane_clamp.sv
module simd_lane_clamp #(
    parameter int NB = 8,
    parameter int BW = 8,
    localparam int WW = NB * BW
) (
    input  logic [WW-1:0] a,
    input  logic [WW-1:0] b_eff,
    input  logic [WW-1:0] sum,
    input  logic [NB-1:0] cout,
    input  logic [NB-1:0] last_byte,
    input  logic          sub_en,
    input  logic          signed_en,
    input  logic          sat_en,
    output logic [WW-1:0] result,
    output logic [NB-1:0] lane_ovf
);

    typedef struct packed {
        logic [WW-1:0] res;
        logic [NB-1:0] ovf;
    } fix_t;

    fix_t          fix_d;
    logic [NB-1:0] ovf_here;
    logic [NB-1:0] up_here;
    logic [NB-1:0] up_lane;
    logic          ma, mb, ms;

    always_comb begin
        ma = 1'b0;
        mb = 1'b0;
        ms = 1'b0;
        for (int i = 0; i < NB; i++) begin
            ma = a[i*BW + BW - 1];
            mb = b_eff[i*BW + BW - 1];
            ms = sum[i*BW + BW - 1];
            if (signed_en) begin
                ovf_here[i] = (ma == mb) && (ms != ma);
                up_here[i]  = ~ma;
            end else begin
                ovf_here[i] = sub_en ? ~cout[i] : cout[i];
                up_here[i]  = ~sub_en;
            end
        end
        // spread each lane's top-byte verdict down over its lower bytes
        fix_d.ovf = '0;
        up_lane   = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (last_byte[i] || i == NB - 1) begin
                fix_d.ovf[i] = ovf_here[i];
                up_lane[i]   = up_here[i];
            end else begin
                fix_d.ovf[i] = fix_d.ovf[i+1];
                up_lane[i]   = up_lane[i+1];
            end
        end
        fix_d.res = sum;
        for (int i = 0; i < NB; i++) begin
            if (sat_en && fix_d.ovf[i]) begin
                if (signed_en && last_byte[i])
                    fix_d.res[i*BW +: BW] = {~up_lane[i], {(BW-1){up_lane[i]}}};
                else
                    fix_d.res[i*BW +: BW] = {BW{up_lane[i]}};
            end
        end
    end

    assign result   = fix_d.res;
    assign lane_ovf = fix_d.ovf;

    always_comb begin
        // R8
        wrap_passthru_chk: assert (sat_en || (result == sum))
            else $error("wrap mode altered the sum");
        for (int i = 0; i < NB; i++) begin
            // R7
            if (i < NB - 1 && !last_byte[i]) begin
                ovf_lane_uniform_chk: assert (lane_ovf[i] == lane_ovf[i+1])
                    else $error("overflow flag differs inside one lane");
            end
            // R11
            no_overflow_chk: assert (lane_ovf[i] || (result[i*BW +: BW] == sum[i*BW +: BW]))
                else $error("non-overflowing byte was modified");
            // R10
            if (sat_en && !signed_en && !sub_en && lane_ovf[i]) begin
                usat_add_chk: assert (&result[i*BW +: BW])
                    else $error("unsigned add clamp is not all ones");
            end
        end
    end

endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
    import simd_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int BYTE_W = 8,
    localparam int NB    = WORD_W / BYTE_W
) (
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [1:0]        lane_sel,
    input  logic              sub_en,
    input  logic              signed_en,
    input  logic              sat_en,
    output logic [WORD_W-1:0] result,
    output logic [NB-1:0]     lane_ovf
);

    logic [NB-1:0]     first_byte;
    logic [NB-1:0]     last_byte;
    logic [WORD_W-1:0] sum_w;
    logic [WORD_W-1:0] beff_w;
    logic [NB-1:0]     cout_w;

    simd_lane_map #(.NB(NB)) u_map (
        .lane_sel  (lane_sel),
        .first_byte(first_byte),
        .last_byte (last_byte)
    );

    simd_slice_chain #(.NB(NB), .BW(BYTE_W)) u_chain (
        .a         (op_a),
        .b         (op_b),
        .sub_en    (sub_en),
        .first_byte(first_byte),
        .sum       (sum_w),
        .b_eff     (beff_w),
        .cout      (cout_w)
    );

    simd_lane_clamp #(.NB(NB), .BW(BYTE_W)) u_clamp (
        .a        (op_a),
        .b_eff    (beff_w),
        .sum      (sum_w),
        .cout     (cout_w),
        .last_byte(last_byte),
        .sub_en   (sub_en),
        .signed_en(signed_en),
        .sat_en   (sat_en),
        .result   (result),
        .lane_ovf (lane_ovf)
    );

    always_comb begin
        for (int i = 0; i < NB; i++) begin
            // R4
            if (signed_en && !sub_en && last_byte[i] &&
                (op_a[i*BYTE_W + BYTE_W - 1] != op_b[i*BYTE_W + BYTE_W - 1])) begin
                mixed_sign_add_chk: assert (!lane_ovf[i])
                    else $error("opposite-sign add flagged overflow");
            end
        end
    end

endmodule

// File: tb/sim_simd_sat_adder.sv
module sim_simd_sat_adder;

    logic        clk = 1'b0;
    logic [63:0] op_a, op_b;
    logic [1:0]  lane_sel;
    logic        sub_en, signed_en, sat_en;
    logic [63:0] dut_res;
    logic [7:0]  dut_ovf;
    int          n_tests = 0;
    int          n_fail  = 0;
    bit          done    = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    simd_sat_adder u0 (
        .op_a     (op_a),
        .op_b     (op_b),
        .lane_sel (lane_sel),
        .sub_en   (sub_en),
        .signed_en(signed_en),
        .sat_en   (sat_en),
        .result   (dut_res),
        .lane_ovf (dut_ovf)
    );

    function automatic void ref_model(input logic [63:0] a, input logic [63:0] b,
                                      input logic [1:0] ls, input logic sub,
                                      input logic sgn, input logic sat,
                                      output logic [63:0] r, output logic [7:0] o);
        int L, nl, bpl;
        logic [66:0] m, x, y, s, val, lane, t;
        logic signed [66:0] sx, sy, ss, hi, lo;
        logic of;
        L   = 8 << ls;
        nl  = 64 / L;
        bpl = L / 8;
        r   = '0;
        o   = '0;
        for (int k = 0; k < nl; k++) begin
            m  = (67'd1 << L) - 67'd1;
            x  = ({3'b0, a} >> (k * L)) & m;
            y  = ({3'b0, b} >> (k * L)) & m;
            s  = sub ? (x - y) : (x + y);
            sx = x[L-1] ? ($signed(x) - $signed(67'd1 << L)) : $signed(x);
            sy = y[L-1] ? ($signed(y) - $signed(67'd1 << L)) : $signed(y);
            ss = sub ? (sx - sy) : (sx + sy);
            hi = $signed((67'd1 << (L - 1)) - 67'd1);
            lo = -hi - 67'sd1;
            if (sgn) begin
                of  = (ss > hi) || (ss < lo);
                val = (ss > hi) ? $unsigned(hi) : $unsigned(lo);
            end else begin
                of  = sub ? (x < y) : s[L];
                val = sub ? 67'd0 : m;
            end
            lane = (sat && of) ? (val & m) : (s & m);
            t    = lane << (k * L);
            r    = r | t[63:0];
            for (int j = 0; j < bpl; j++) o[k*bpl + j] = of;
        end
    endfunction

    task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic [1:0] ls,
                         input logic sub, input logic sgn, input logic sat);
        @(posedge clk);
        op_a = a; op_b = b; lane_sel = ls;
        sub_en = sub; signed_en = sgn; sat_en = sat;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [63:0] er, input logic [7:0] eo);
        n_tests++;
        if (dut_res !== er || dut_ovf !== eo) begin
            n_fail++;
            $display("FAIL %s: result=%h ovf=%b expected result=%h ovf=%b",
                     tag, dut_res, dut_ovf, er, eo);
        end
    endtask

    function automatic logic [7:0] pick_byte();
        case ($urandom % 6)
            0: return 8'h00;
            1: return 8'h7F;
            2: return 8'h80;
            3: return 8'hFF;
            4: return 8'h01;
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: result=%h ovf=%b expected result=done ovf=done",
                     dut_res, dut_ovf);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] ea, eb, er;
        logic [7:0]  eo;
        void'($urandom(32'd4242));

        // R2 idle state: all-zero operands
        drive(64'h0, 64'h0, 2'b00, 1'b0, 1'b0, 1'b0);
        check("R2 zero inputs", 64'h0, 8'h00);

        // R1 carry stops at 8-bit boundary, crosses inside 16-bit lane
        drive(64'h00000000_000000FF, 64'h1, 2'b00, 1'b0, 1'b0, 1'b0);
        check("R1 byte carry isolated", 64'h0, 8'h01);
        drive(64'h00000000_000000FF, 64'h1, 2'b01, 1'b0, 1'b0, 1'b0);
        check("R1 carry inside 16-bit lane", 64'h0000_0000_0000_0100, 8'h00);
        drive(64'h00000000_FFFFFFFF, 64'h1, 2'b10, 1'b0, 1'b0, 1'b0);
        check("R1 32-bit lane boundary", 64'h0, 8'h0F);
        drive(64'h00000000_FFFFFFFF, 64'h1, 2'b11, 1'b0, 1'b0, 1'b0);
        check("R1 64-bit single lane", 64'h00000001_00000000, 8'h00);

        // R3 R6 unsigned subtract with borrow in byte 0 only
        drive(64'h05, 64'h07, 2'b00, 1'b1, 1'b0, 1'b0);
        check("R3 R6 unsigned borrow wrap", 64'hFE, 8'h01);

        // R8 signed wrap keeps modulo value but flags
        drive(64'h7F, 64'h01, 2'b00, 1'b0, 1'b1, 1'b0);
        check("R8 signed wrap", 64'h80, 8'h01);

        // R9 signed clamps
        drive(64'h7F, 64'h01, 2'b00, 1'b0, 1'b1, 1'b1);
        check("R9 signed clamp up 8", 64'h7F, 8'h01);
        drive(64'h80, 64'h01, 2'b00, 1'b1, 1'b1, 1'b1);
        check("R9 signed clamp down 8", 64'h80, 8'h01);
        drive(64'h7FFF, 64'h01, 2'b01, 1'b0, 1'b1, 1'b1);
        check("R9 R7 signed clamp up 16", 64'h7FFF, 8'h03);
        drive(64'h7FFFFFFF_FFFFFFFF, 64'h1, 2'b11, 1'b0, 1'b1, 1'b1);
        check("R9 R7 signed clamp up 64", 64'h7FFFFFFF_FFFFFFFF, 8'hFF);
        drive(64'h80000000_00000000, 64'h1, 2'b11, 1'b1, 1'b1, 1'b1);
        check("R9 signed clamp down 64", 64'h80000000_00000000, 8'hFF);

        // R10 unsigned clamps
        drive(64'hFF, 64'h01, 2'b00, 1'b0, 1'b0, 1'b1);
        check("R10 unsigned clamp high", 64'hFF, 8'h01);
        drive(64'h0, 64'h01, 2'b10, 1'b1, 1'b0, 1'b1);
        check("R10 R7 unsigned clamp zero 32", 64'h0, 8'h0F);

        // R4 opposite-sign add never overflows
        drive(64'h7F, 64'h80, 2'b00, 1'b0, 1'b1, 1'b1);
        check("R4 mixed sign add", 64'hFF, 8'h00);

        // R5 positive minus negative overflows upward
        drive(64'h7F, 64'h80, 2'b00, 1'b1, 1'b1, 1'b1);
        check("R5 signed sub overflow", 64'h7F, 8'h01);

        // R11 saturating mode, no overflow
        drive(64'h10, 64'h20, 2'b00, 1'b0, 1'b1, 1'b1);
        check("R11 sat no overflow", 64'h30, 8'h00);

        // random mix against the bench model
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] ls;
            logic sub, sgn, sat;
            for (int k = 0; k < 8; k++) begin
                ea[k*8 +: 8] = pick_byte();
                eb[k*8 +: 8] = pick_byte();
            end
            ls  = 2'($urandom);
            sub = 1'($urandom);
            sgn = 1'($urandom);
            sat = 1'($urandom);
            ref_model(ea, eb, ls, sub, sgn, sat, er, eo);
            drive(ea, eb, ls, sub, sgn, sat);
            if (sat)
                check(sgn ? "R9 R4 R5 random signed clamp" : "R10 R6 random unsigned clamp", er, eo);
            else
                check(sub ? "R3 R1 R7 random wrap sub" : "R2 R1 R7 random wrap add", er, eo);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule